// File: doc/BRIEF.md
# Byte-Wide ADC Readout Controller

This block runs a converter from the host side. It needs only eight data lines, a chip select, a read strobe, a byte-select line, an active-low conversion start and a converter reset. A start request drives the conversion-start line low. The block then waits for the converter's busy flag to drop. It fetches the result in two reads, and both halves arrive on the same eight pins. The first half is the upper byte, read with byte-select low. The second half is the lower byte, read with byte-select high. The 16-bit word is presented with a one-cycle valid strobe.

All nanosecond limits are parameters that are rounded up to whole clock cycles. No read may fall inside a guard window around any falling edge of conversion start, so a start request that arrives during a read is held until the read ends and the pre-edge gap has passed. A parameter chooses how the two halves are read: either the read strobe is raised between them, or it is held low and only byte-select changes. An abort request pulses conversion start again while chip select is low and the converter is busy. This cancels the conversion, and no word is produced.

Top module: `adc_byte_reader`

## Requirements
- R1: While rst_ni is low and after it rises, adc_rst_no stays low for RST_CYC = ceil(RST_LOW_NS/CLK_PERIOD_NS) cycles (2 by default). cs_no, rd_no and convst_no are high, valid_o is 0 and word_o is 0 in reset, and there is no conversion start while adc_rst_no is low.
- R2: A start request makes convst_no go low exactly once, with cs_no low, and only while busy_i is low.
- R3: rd_no is low only when cs_no is low, and no read happens while the converter reports busy.
- R4: The first read has byte_o = 0 and its data_i becomes word_o[15:8]. The second read has byte_o = 1 and its data_i becomes word_o[7:0].
- R5: Each completed conversion gives exactly one single-cycle valid_o pulse, and word_o holds its value until the next pulse.
- R6: No cycle with cs_no and rd_no both low occurs until more than POST_CYC = ceil(POST_GUARD_NS/CLK_PERIOD_NS) cycles after the first low cycle of convst_no.
- R7: At least PRE_CYC = ceil(PRE_GUARD_NS/CLK_PERIOD_NS) cycles with no read lie between the last read cycle and a falling edge of convst_no.
- R8: A start request during a read is remembered and carried out once the read and the R7 gap are over, and its result is still delivered.
- R9: With TOGGLE_RD = 1, rd_no rises between the two halves and byte_o changes only while rd_no is high, giving two rd_no falling edges per word. With TOGGLE_RD = 0, rd_no stays low across both halves, giving one falling edge per word.
- R10: An abort_i while waiting on a busy converter (cs_no low, busy_i high) gives one more convst_no low pulse. No read and no valid_o follow, and cs_no returns high.
- R11: An abort_i while idle has no effect: convst_no does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request (pulse) |
| abort_i | input | 1 | Abort request (pulse) |
| busy_i | input | 1 | Converter busy flag |
| data_i | input | BUS_W | Upper data pins of the converter |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| convst_no | output | 1 | Conversion start, active low |
| byte_o | output | 1 | Byte select: 0 upper half, 1 lower half |
| adc_rst_no | output | 1 | Converter reset, active low |
| word_o | output | 2*BUS_W | Assembled result |
| valid_o | output | 1 | One-cycle strobe for a new word_o |

## Verification
The assertions assume that the converter raises busy_i within the convst_no low pulse, keeps it high until its result is ready, and holds data_i stable for as long as a read is active. The bench meets these conditions with a cycle-level converter model. The model raises busy one cycle after it sees the falling edge and holds it for a random 3 to 12 cycles. It drives the selected byte only during a read and drives a fixed filler byte at all other times. Abort requests are issued only while busy is high, or on purpose while the block is idle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [3:0] {
    ST_RST,
    ST_IDLE,
    ST_CONV,
    ST_POST,
    ST_BUSY,
    ST_HI,
    ST_GAP,
    ST_LO,
    ST_ABORT
  } rd_state_e;

  // ns to whole cycles, rounded up, never below one
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned r;
    r = (ns + per - 1) / per;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_guard.sv
module adc_rd_guard #(
  parameter int unsigned PRE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_act_i,
  output logic clear_o
);
  localparam int unsigned W = $clog2(PRE_CYC + 1);

  logic [W-1:0] gap_q;

  // reload on every read cycle, count down afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
    end else if (rd_act_i) begin
      gap_q <= W'(PRE_CYC);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign clear_o = (gap_q == '0) && !rd_act_i;
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned RST_CYC   = 2,
  parameter int unsigned CV_CYC    = 2,
  parameter int unsigned POST_CYC  = 2,
  parameter int unsigned RD_CYC    = 2,
  parameter bit          TOGGLE_RD = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic busy_i,
  input  logic guard_clr_i,
  output logic cs_no,
  output logic rd_no,
  output logic convst_no,
  output logic byte_o,
  output logic adc_rst_no,
  output logic cap_hi_o,
  output logic cap_lo_o
);
  localparam int unsigned MAX_CYC = max2(max2(RST_CYC, CV_CYC), max2(POST_CYC, RD_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  rd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             cnt_done;
  logic             abort_ok;

  assign cnt_done = (cnt_q == '0);
  assign abort_ok = abort_i && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
      cnt_q   <= CNT_W'(RST_CYC - 1);
      pend_q  <= 1'b0;
    end else begin
      if (start_i) pend_q <= 1'b1;
      case (state_q)
        ST_RST: begin
          if (cnt_done) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        ST_IDLE: begin
          if ((pend_q || start_i) && guard_clr_i && !busy_i) begin
            state_q <= ST_CONV;
            cnt_q   <= CNT_W'(CV_CYC - 1);
            pend_q  <= 1'b0;
          end
        end
        ST_CONV: begin
          if (cnt_done) begin
            state_q <= ST_POST;
            cnt_q   <= CNT_W'(POST_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_POST: begin
          if (abort_ok) begin
            state_q <= ST_ABORT;
            cnt_q   <= CNT_W'(CV_CYC - 1);
          end else if (cnt_done) begin
            state_q <= ST_BUSY;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_BUSY: begin
          if (abort_ok) begin
            state_q <= ST_ABORT;
            cnt_q   <= CNT_W'(CV_CYC - 1);
          end else if (!busy_i) begin
            state_q <= ST_HI;
            cnt_q   <= CNT_W'(RD_CYC - 1);
          end
        end
        ST_HI: begin
          if (cnt_done) begin
            state_q <= TOGGLE_RD ? ST_GAP : ST_LO;
            cnt_q   <= CNT_W'(RD_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_GAP: begin
          state_q <= ST_LO;
          cnt_q   <= CNT_W'(RD_CYC - 1);
        end
        ST_LO: begin
          if (cnt_done) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        ST_ABORT: begin
          if (cnt_done) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // outputs decoded from registered state only
  always_comb begin
    adc_rst_no = (state_q != ST_RST);
    cs_no      = (state_q == ST_RST) || (state_q == ST_IDLE);
    convst_no  = !((state_q == ST_CONV) || (state_q == ST_ABORT));
    rd_no      = !((state_q == ST_HI) || (state_q == ST_LO));
    byte_o     = (state_q == ST_GAP) || (state_q == ST_LO);
    cap_hi_o   = (state_q == ST_HI) && cnt_done;
    cap_lo_o   = (state_q == ST_LO) && cnt_done;
  end
endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble #(
  parameter int unsigned BUS_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_hi_i,
  input  logic               cap_lo_i,
  input  logic [BUS_W-1:0]   data_i,
  output logic [2*BUS_W-1:0] word_o,
  output logic               valid_o
);
  logic [BUS_W-1:0]   hi_q;
  logic [2*BUS_W-1:0] word_q;
  logic               valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap_lo_i;
      if (cap_hi_i) hi_q   <= data_i;
      if (cap_lo_i) word_q <= {hi_q, data_i};
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned BUS_W         = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned PRE_GUARD_NS  = 50,
  parameter int unsigned POST_GUARD_NS = 40,
  parameter int unsigned RST_LOW_NS    = 25,
  parameter int unsigned CONVST_LOW_NS = 40,
  parameter int unsigned RD_ACCESS_NS  = 40,
  parameter bit          TOGGLE_RD     = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic               busy_i,
  input  logic [BUS_W-1:0]   data_i,
  output logic               cs_no,
  output logic               rd_no,
  output logic               convst_no,
  output logic               byte_o,
  output logic               adc_rst_no,
  output logic [2*BUS_W-1:0] word_o,
  output logic               valid_o
);
  localparam int unsigned PRE_CYC  = ns2cyc(PRE_GUARD_NS, CLK_PERIOD_NS);
  localparam int unsigned POST_CYC = ns2cyc(POST_GUARD_NS, CLK_PERIOD_NS);
  localparam int unsigned RST_CYC  = ns2cyc(RST_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned CV_CYC   = ns2cyc(CONVST_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC   = ns2cyc(RD_ACCESS_NS, CLK_PERIOD_NS);

  logic guard_clr;
  logic cap_hi, cap_lo;
  logic cs_n, rd_n;

  adc_rd_guard #(.PRE_CYC(PRE_CYC)) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_act_i(!cs_n && !rd_n),
    .clear_o (guard_clr)
  );

  adc_rd_seq #(
    .RST_CYC  (RST_CYC),
    .CV_CYC   (CV_CYC),
    .POST_CYC (POST_CYC),
    .RD_CYC   (RD_CYC),
    .TOGGLE_RD(TOGGLE_RD)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .busy_i     (busy_i),
    .guard_clr_i(guard_clr),
    .cs_no      (cs_n),
    .rd_no      (rd_n),
    .convst_no  (convst_no),
    .byte_o     (byte_o),
    .adc_rst_no (adc_rst_no),
    .cap_hi_o   (cap_hi),
    .cap_lo_o   (cap_lo)
  );

  adc_rd_assemble #(.BUS_W(BUS_W)) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_hi_i(cap_hi),
    .cap_lo_i(cap_lo),
    .data_i  (data_i),
    .word_o  (word_o),
    .valid_o (valid_o)
  );

  assign cs_no = cs_n;
  assign rd_no = rd_n;
endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned PRE_GUARD_NS  = 50,
  parameter int unsigned POST_GUARD_NS = 40,
  parameter int unsigned RST_LOW_NS    = 25,
  parameter bit          TOGGLE_RD     = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic cs_no,
  input logic rd_no,
  input logic convst_no,
  input logic byte_o,
  input logic adc_rst_no,
  input logic valid_o
);
  localparam int unsigned PRE_CYC  = ns2cyc(PRE_GUARD_NS, CLK_PERIOD_NS);
  localparam int unsigned POST_CYC = ns2cyc(POST_GUARD_NS, CLK_PERIOD_NS);
  localparam int unsigned RST_CYC  = ns2cyc(RST_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned SAT      = 1000;

  logic        rd_act;
  int unsigned since_q, idle_q, low_q;
  logic        cv_q;

  assign rd_act = !cs_no && !rd_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= SAT;
      idle_q  <= SAT;
      low_q   <= 0;
      cv_q    <= 1'b1;
    end else begin
      cv_q <= convst_no;
      if (cv_q && !convst_no) since_q <= 1;
      else if (since_q < SAT) since_q <= since_q + 1;
      if (rd_act) idle_q <= 0;
      else if (idle_q < SAT) idle_q <= idle_q + 1;
      if (!adc_rst_no) low_q <= low_q + 1;
    end
  end

  assert_adc_rst_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_rst_no) |-> low_q >= RST_CYC);
  assert_quiet_in_rst_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rst_no |-> cs_no && convst_no && rd_no);
  assert_start_with_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convst_no) |-> !cs_no);
  assert_rd_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !cs_no);
  assert_no_read_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act |-> !busy_i);
  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_post_guard_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act |-> since_q > POST_CYC);
  assert_pre_guard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cv_q && !convst_no) |-> idle_q >= PRE_CYC);

  generate
    if (TOGGLE_RD) begin : g_toggle
      assert_byte_rd_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(byte_o) |-> rd_no);
    end else begin : g_hold
      assert_byte_rd_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(byte_o) |-> !rd_no && !$past(rd_no));
    end
  endgenerate
endmodule

bind adc_byte_reader adc_byte_reader_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .PRE_GUARD_NS (PRE_GUARD_NS),
  .POST_GUARD_NS(POST_GUARD_NS),
  .RST_LOW_NS   (RST_LOW_NS),
  .TOGGLE_RD    (TOGGLE_RD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_i),
  .cs_no     (cs_no),
  .rd_no     (rd_no),
  .convst_no (convst_no),
  .byte_o    (byte_o),
  .adc_rst_no(adc_rst_no),
  .valid_o   (valid_o)
);

// File: tb/tb_adc_byte_reader.sv
module adc_conv_model #(
  parameter int PRE_CYC  = 3,
  parameter int POST_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adc_rst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        convst_n,
  input  logic        byte_sel,
  input  logic [15:0] next_val,
  input  int          len,
  output logic        busy,
  output logic [7:0]  data,
  output int          falls,
  output int          aborts,
  output int          pre_viol,
  output int          post_viol,
  output int          busy_reads,
  output int          rd_falls,
  output int          rst_len
);
  logic        prev_cv, prev_rd, prev_arst, rd_act;
  int          cnt, idle, since, lowcnt;
  logic [15:0] result;

  assign rd_act = !cs_n && !rd_n;
  assign data   = rd_act ? (byte_sel ? result[7:0] : result[15:8]) : 8'h5A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cv <= 1'b1; prev_rd <= 1'b1; prev_arst <= 1'b0;
      busy <= 1'b0; cnt <= 0; idle <= 1000; since <= 1000; lowcnt <= 0;
      result <= 16'h0; falls <= 0; aborts <= 0; pre_viol <= 0; post_viol <= 0;
      busy_reads <= 0; rd_falls <= 0; rst_len <= 0;
    end else begin
      prev_cv <= convst_n; prev_rd <= rd_n; prev_arst <= adc_rst_n;
      if (!adc_rst_n) lowcnt <= lowcnt + 1;
      if (adc_rst_n && !prev_arst) rst_len <= lowcnt;
      if (rd_act) begin
        idle <= 0;
        if (since <= POST_CYC) post_viol <= post_viol + 1;
        if (busy) busy_reads <= busy_reads + 1;
      end else if (idle < 1000) idle <= idle + 1;
      if (since < 1000) since <= since + 1;
      if (prev_rd && !rd_n) rd_falls <= rd_falls + 1;
      if (prev_cv && !convst_n) begin
        falls <= falls + 1;
        since <= 1;
        if (idle < PRE_CYC) pre_viol <= pre_viol + 1;
        if (!cs_n) begin
          if (busy) begin
            busy <= 1'b0; aborts <= aborts + 1;
          end else begin
            busy <= 1'b1; cnt <= len; result <= next_val; rd_falls <= 0;
          end
        end
      end else if (busy) begin
        if (cnt <= 1) busy <= 1'b0;
        else cnt <= cnt - 1;
      end
      if (!adc_rst_n) busy <= 1'b0;
    end
  end
endmodule

module tb_adc_byte_reader;
  localparam int CLK_NS   = 20;
  localparam int PRE_CYC  = (50 + CLK_NS - 1) / CLK_NS;
  localparam int POST_CYC = (40 + CLK_NS - 1) / CLK_NS;
  localparam int RST_CYC  = (25 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        start_s[2], abort_s[2];
  logic        cs_n[2], rd_n[2], cv_n[2], byte_s[2], arst_n[2], valid[2], busy[2];
  logic [15:0] word[2], nval[2];
  logic [7:0]  data[2];
  int          len[2], falls[2], aborts[2], pre_v[2], post_v[2], busy_r[2], rdf[2], rst_len[2];

  int          checks = 0, fails = 0;
  int          got_cnt[2], rd_cs_bad[2], dbl_valid[2];
  logic [15:0] got_word[2];
  logic        prev_valid[2];
  bit          done = 1'b0;

  adc_byte_reader #(.TOGGLE_RD(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s[0]), .abort_i(abort_s[0]),
    .busy_i(busy[0]), .data_i(data[0]), .cs_no(cs_n[0]), .rd_no(rd_n[0]),
    .convst_no(cv_n[0]), .byte_o(byte_s[0]), .adc_rst_no(arst_n[0]),
    .word_o(word[0]), .valid_o(valid[0]));

  adc_byte_reader #(.TOGGLE_RD(1'b0)) dut_hold (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s[1]), .abort_i(abort_s[1]),
    .busy_i(busy[1]), .data_i(data[1]), .cs_no(cs_n[1]), .rd_no(rd_n[1]),
    .convst_no(cv_n[1]), .byte_o(byte_s[1]), .adc_rst_no(arst_n[1]),
    .word_o(word[1]), .valid_o(valid[1]));

  adc_conv_model #(.PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)) m0 (
    .clk(clk), .rst_n(rst_n), .adc_rst_n(arst_n[0]), .cs_n(cs_n[0]), .rd_n(rd_n[0]),
    .convst_n(cv_n[0]), .byte_sel(byte_s[0]), .next_val(nval[0]), .len(len[0]),
    .busy(busy[0]), .data(data[0]), .falls(falls[0]), .aborts(aborts[0]),
    .pre_viol(pre_v[0]), .post_viol(post_v[0]), .busy_reads(busy_r[0]),
    .rd_falls(rdf[0]), .rst_len(rst_len[0]));

  adc_conv_model #(.PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)) m1 (
    .clk(clk), .rst_n(rst_n), .adc_rst_n(arst_n[1]), .cs_n(cs_n[1]), .rd_n(rd_n[1]),
    .convst_n(cv_n[1]), .byte_sel(byte_s[1]), .next_val(nval[1]), .len(len[1]),
    .busy(busy[1]), .data(data[1]), .falls(falls[1]), .aborts(aborts[1]),
    .pre_viol(pre_v[1]), .post_viol(post_v[1]), .busy_reads(busy_r[1]),
    .rd_falls(rdf[1]), .rst_len(rst_len[1]));

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst_n) begin
        if (valid[i]) begin
          got_cnt[i]  = got_cnt[i] + 1;
          got_word[i] = word[i];
          if (prev_valid[i]) dbl_valid[i] = dbl_valid[i] + 1;
        end
        if (!rd_n[i] && cs_n[i]) rd_cs_bad[i] = rd_cs_bad[i] + 1;
      end
      prev_valid[i] = valid[i];
    end
  end

  task automatic chk(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(int i);
    @(negedge clk) start_s[i] = 1'b1;
    @(negedge clk) start_s[i] = 1'b0;
  endtask

  task automatic pulse_abort(int i);
    @(negedge clk) abort_s[i] = 1'b1;
    @(negedge clk) abort_s[i] = 1'b0;
  endtask

  task automatic wait_new(int i, int g0);
    for (int k = 0; k < 400 && got_cnt[i] == g0; k++) @(negedge clk);
  endtask

  function automatic int exp_rdf(int i);
    return (i == 0) ? 2 : 1;
  endfunction

  task automatic run_conv(int i, logic [15:0] v, int l);
    int g0, f0;
    nval[i] = v; len[i] = l;
    g0 = got_cnt[i]; f0 = falls[i];
    pulse_start(i);
    wait_new(i, g0);
    chk("R4 word", got_word[i] == v, 32'(got_word[i]), 32'(v));
    chk("R5 one valid", got_cnt[i] == g0 + 1, got_cnt[i], g0 + 1);
    chk("R2 one start edge", falls[i] == f0 + 1, falls[i], f0 + 1);
    chk("R9 rd falls per word", rdf[i] == exp_rdf(i), rdf[i], exp_rdf(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 2; i++) begin
      start_s[i] = 0; abort_s[i] = 0; nval[i] = 0; len[i] = 4;
      got_cnt[i] = 0; rd_cs_bad[i] = 0; dbl_valid[i] = 0; prev_valid[i] = 0;
      got_word[i] = 0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      // R1 reset state
      chk("R1 rst outputs", cs_n[i] && rd_n[i] && cv_n[i] && !valid[i] && !arst_n[i],
          {cs_n[i], rd_n[i], cv_n[i], valid[i], arst_n[i]}, 5'b11100);
      chk("R1 rst word", word[i] == 16'h0, 32'(word[i]), 0);
    end
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk("R1 adc reset length", rst_len[i] == RST_CYC, rst_len[i], RST_CYC);
      chk("R1 adc reset released", arst_n[i] == 1'b1, arst_n[i], 1);
    end

    for (int i = 0; i < 2; i++) begin
      // R4 directed corner codes
      run_conv(i, 16'hFFFF, 4);
      run_conv(i, 16'h0000, 3);
      run_conv(i, 16'h8000, 5);
      run_conv(i, 16'h7FFF, 7);
      run_conv(i, 16'h00FF, 3);
      run_conv(i, 16'hFF00, 12);
      // R5 word holds after strobe
      repeat (5) @(negedge clk);
      chk("R5 word hold", word[i] == 16'hFF00, 32'(word[i]), 32'hFF00);

      // R11 abort while idle ignored
      begin
        int f0;
        f0 = falls[i];
        pulse_abort(i);
        repeat (10) @(negedge clk);
        chk("R11 idle abort no edge", falls[i] == f0, falls[i], f0);
        chk("R11 idle abort convst high", cv_n[i] == 1'b1, cv_n[i], 1);
      end

      // R10 abort during conversion
      begin
        int g0, f0, a0;
        g0 = got_cnt[i]; f0 = falls[i]; a0 = aborts[i];
        nval[i] = 16'h1234; len[i] = 12;
        pulse_start(i);
        for (int k = 0; k < 50 && !busy[i]; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        pulse_abort(i);
        repeat (30) @(negedge clk);
        chk("R10 no valid after abort", got_cnt[i] == g0, got_cnt[i], g0);
        chk("R10 abort seen", aborts[i] == a0 + 1, aborts[i], a0 + 1);
        chk("R10 second edge", falls[i] == f0 + 2, falls[i], f0 + 2);
        chk("R10 cs released", cs_n[i] == 1'b1, cs_n[i], 1);
      end
      run_conv(i, 16'hA55A, 6);

      // R8 start during read is deferred
      begin
        int g0, f0;
        g0 = got_cnt[i]; f0 = falls[i];
        nval[i] = 16'h3C3C; len[i] = 4;
        pulse_start(i);
        for (int k = 0; k < 100 && !(!rd_n[i] && !cs_n[i]); k++) @(negedge clk);
        nval[i] = 16'hC3A1;
        pulse_start(i);
        wait_new(i, g0);
        chk("R8 first word", got_word[i] == 16'h3C3C, 32'(got_word[i]), 32'h3C3C);
        wait_new(i, g0 + 1);
        chk("R8 deferred word", got_word[i] == 16'hC3A1, 32'(got_word[i]), 32'hC3A1);
        chk("R8 two edges", falls[i] == f0 + 2, falls[i], f0 + 2);
        chk("R7 gap after deferred", pre_v[i] == 0, pre_v[i], 0);
      end

      // random patterns
      for (int n = 0; n < 30; n++) begin
        run_conv(i, 16'($urandom), 3 + int'($urandom % 10));
        repeat (int'($urandom % 4)) @(negedge clk);
      end

      chk("R6 post guard", post_v[i] == 0, post_v[i], 0);
      chk("R7 pre guard", pre_v[i] == 0, pre_v[i], 0);
      chk("R3 no read while busy", busy_r[i] == 0, busy_r[i], 0);
      chk("R3 rd only with cs", rd_cs_bad[i] == 0, rd_cs_bad[i], 0);
      chk("R5 single cycle valid", dbl_valid[i] == 0, dbl_valid[i], 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule